// File: doc/BRIEF.md
# Sweep Maximum Power Search Controller

This block locates the most productive operating point of a power source by brute force. When enabled it walks a voltage setpoint upward in fixed increments from a configured floor to a configured ceiling (the open-circuit level). At every point it lets the external regulation loop settle, asks for one power reading, and keeps a running maximum together with the setpoint that produced it.

When the ceiling has been measured, the controller flags completion for one cycle and moves the setpoint to the best point found. It keeps it there for a programmable number of cycles. It then scans again if still enabled, or goes idle if not. The arithmetic that turns voltage and current into power, and the loop that drives the converter to the setpoint, sit outside this block. The block only sees a power word with a valid strobe.

Top module: `sweep_mpp_ctrl`

## Requirements
- R1: After reset, `vset`, `best_v` and `best_p` are zero and `meas_req` and `done` are low.
- R2: A scan starts when `run` is high in the idle state, or at the end of a hold interval. On the first clock of a scan `vset` takes `cfg_vmin`, `best_p` is cleared to zero and `best_v` takes `cfg_vmin`.
- R3: After every setpoint change inside a scan, `meas_req` goes high exactly `cfg_settle`+1 clocks later. It stays high, with `vset` unchanged, until a clock on which `pwr_valid` is high.
- R4: A power word is taken only on a clock where both `meas_req` and `pwr_valid` are high. A `pwr_valid` pulse at any other time changes neither `best_p` nor `best_v`.
- R5: A taken sample replaces `best_p` and `best_v` (the latter with the current `vset`) only when it is strictly greater than `best_p`. On equal power the lower, earlier setpoint is kept.
- R6: After a taken sample with `vset` below `cfg_voc`, `vset` moves to `vset`+`cfg_step`, clamped to `cfg_voc`. A `cfg_step` of zero advances by one.
- R7: A sample taken while `vset` is at or above `cfg_voc` ends the scan. On the next clock `done` is high for exactly one cycle. On the clock after that, `vset` equals `best_v`.
- R8: `vset` is held at `best_v` for `cfg_hold`+1 clocks after the `done` cycle, with `meas_req` low. Then a new scan begins if `run` is high; otherwise the block idles with `meas_req` low.
- R9: If `cfg_vmin` is at or above `cfg_voc`, a scan consists of exactly one measurement at `cfg_vmin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enable scanning; sampled in idle and at the end of a hold |
| cfg_vmin | input | SP_W | First setpoint of a scan |
| cfg_voc | input | SP_W | Last (open-circuit) setpoint of a scan |
| cfg_step | input | SP_W | Setpoint increment; zero acts as one |
| cfg_settle | input | TMR_W | Settling wait, in clocks minus one |
| cfg_hold | input | TMR_W | Hold interval at the optimum, in clocks minus one |
| pwr_in | input | PWR_W | Power reading |
| pwr_valid | input | 1 | Strobe qualifying `pwr_in` |
| vset | output | SP_W | Voltage setpoint to the regulation loop |
| meas_req | output | 1 | Request for a power reading at the current setpoint |
| done | output | 1 | One-cycle pulse when a scan finishes |
| best_v | output | SP_W | Setpoint of the highest power seen in the current scan |
| best_p | output | PWR_W | Highest power seen in the current scan |

## Verification
The embedded properties watch, on every cycle, that the running maximum never falls within a scan and never moves without a taken sample. They also check that the setpoint freezes while a reading is awaited and rises after each taken sample, that completion is a single-cycle pulse, that the hold state always drives the stored optimum, and that a scan start clears the maximum. The directed scenarios show what only a whole scan reveals: the exact list of visited setpoints including the clamped last step, the settle and hold cycle counts, tie handling on flat and twin-peak curves, stray strobes during settling, late responses, a degenerate floor above the ceiling, and the choice between rescanning and idling.

// File: rtl/smc_pkg.sv
package smc_pkg;

    // Default widths shared by the controller and its parts
    localparam int SP_W_DEF  = 10;
    localparam int PWR_W_DEF = 16;
    localparam int TMR_W_DEF = 16;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SETTLE  = 3'd1,
        ST_MEASURE = 3'd2,
        ST_PARK    = 3'd3,
        ST_HOLD    = 3'd4
    } smc_state_e;

    // States in which the interval timer is meaningful
    function automatic logic timed_state(input smc_state_e st);
        return (st == ST_SETTLE) || (st == ST_HOLD);
    endfunction

endpackage

// File: rtl/smc_interval.sv
module smc_interval #(
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [TMR_W-1:0] limit,
    output logic             expired
);

    logic [TMR_W-1:0] cnt;

    assign expired = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/smc_peak.sv
module smc_peak #(
    parameter int SP_W  = 10,
    parameter int PWR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic [SP_W-1:0]  init_v,
    input  logic             sample_en,
    input  logic [PWR_W-1:0] pwr,
    input  logic [SP_W-1:0]  v_now,
    output logic [SP_W-1:0]  best_v,
    output logic [PWR_W-1:0] best_p
);

    logic gain;

    // strict comparison keeps the earlier point on a tie
    assign gain = sample_en && (pwr > best_p);

    always_ff @(posedge clk) begin
        if (rst) begin
            best_p <= '0;
            best_v <= '0;
        end else if (clr) begin
            best_p <= '0;
            best_v <= init_v;
        end else if (gain) begin
            best_p <= pwr;
            best_v <= v_now;
        end
    end

    // R5: the running maximum never falls inside a scan
    a_r5_no_drop: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (best_p >= $past(best_p)));

    // R4: without a taken sample the record is frozen
    a_r4_quiet: assert property (@(posedge clk) disable iff (rst)
        (!clr && !sample_en) |=> ($stable(best_p) && $stable(best_v)));

endmodule

// File: rtl/smc_seq.sv
module smc_seq
    import smc_pkg::*;
#(
    parameter int SP_W  = 10,
    parameter int PWR_W = 16,
    parameter int TMR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SP_W-1:0]  cfg_vmin,
    input  logic [SP_W-1:0]  cfg_voc,
    input  logic [SP_W-1:0]  cfg_step,
    input  logic [TMR_W-1:0] cfg_settle,
    input  logic [TMR_W-1:0] cfg_hold,
    input  logic             pwr_valid,
    input  logic             tmr_expired,
    input  logic [SP_W-1:0]  best_v,
    input  logic [PWR_W-1:0] best_p,
    output logic [SP_W-1:0]  vset,
    output logic             tmr_clr,
    output logic [TMR_W-1:0] tmr_limit,
    output logic             pk_clr,
    output logic             pk_sample,
    output logic             meas_req,
    output logic             done
);

    localparam int SUM_W = SP_W + 1;

    smc_state_e       state, state_n;
    logic [SP_W-1:0]  vset_n;
    logic [SP_W-1:0]  step_eff;
    logic [SUM_W-1:0] sum_wide;
    logic [SP_W-1:0]  v_next;
    logic             at_top;
    logic             start_scan;

    assign step_eff = (cfg_step == '0) ? {{(SP_W-1){1'b0}}, 1'b1} : cfg_step;
    assign sum_wide = {1'b0, vset} + {1'b0, step_eff};
    assign v_next   = (sum_wide >= {1'b0, cfg_voc}) ? cfg_voc : sum_wide[SP_W-1:0];
    assign at_top   = (vset >= cfg_voc);

    assign meas_req  = (state == ST_MEASURE);
    assign done      = (state == ST_PARK);
    assign tmr_limit = (state == ST_HOLD) ? cfg_hold : cfg_settle;
    assign tmr_clr   = (state_n != state) && timed_state(state_n);
    assign pk_sample = meas_req && pwr_valid;
    assign pk_clr    = start_scan;

    always_comb begin
        state_n    = state;
        vset_n     = vset;
        start_scan = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (run) begin
                    start_scan = 1'b1;
                end
            end
            ST_SETTLE: begin
                if (tmr_expired) begin
                    state_n = ST_MEASURE;
                end
            end
            ST_MEASURE: begin
                if (pwr_valid) begin
                    if (at_top) begin
                        state_n = ST_PARK;
                    end else begin
                        state_n = ST_SETTLE;
                        vset_n  = v_next;
                    end
                end
            end
            ST_PARK: begin
                state_n = ST_HOLD;
                vset_n  = best_v;
            end
            ST_HOLD: begin
                if (tmr_expired) begin
                    if (run) begin
                        start_scan = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (start_scan) begin
            state_n = ST_SETTLE;
            vset_n  = cfg_vmin;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            vset  <= '0;
        end else begin
            state <= state_n;
            vset  <= vset_n;
        end
    end

    // R3: setpoint frozen while a reading is outstanding
    a_r3_freeze: assert property (@(posedge clk) disable iff (rst)
        (meas_req && !pwr_valid) |=> $stable(vset));

    // R6: a taken sample below the ceiling raises the setpoint
    a_r6_advance: assert property (@(posedge clk) disable iff (rst)
        (meas_req && pwr_valid && (vset < cfg_voc) && $stable(cfg_voc))
        |=> (vset > $past(vset)));

    // R7: completion lasts one cycle
    a_r7_single_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: hold drives the stored optimum
    a_r8_park_value: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |-> (vset == best_v));

    // R2: a scan starts from a cleared maximum at the floor
    a_r2_fresh: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && run) |=> (best_p == '0 && vset == $past(cfg_vmin)));

endmodule

// File: rtl/sweep_mpp_ctrl.sv
module sweep_mpp_ctrl
    import smc_pkg::*;
#(
    parameter int SP_W  = SP_W_DEF,
    parameter int PWR_W = PWR_W_DEF,
    parameter int TMR_W = TMR_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [SP_W-1:0]  cfg_vmin,
    input  logic [SP_W-1:0]  cfg_voc,
    input  logic [SP_W-1:0]  cfg_step,
    input  logic [TMR_W-1:0] cfg_settle,
    input  logic [TMR_W-1:0] cfg_hold,
    input  logic [PWR_W-1:0] pwr_in,
    input  logic             pwr_valid,
    output logic [SP_W-1:0]  vset,
    output logic             meas_req,
    output logic             done,
    output logic [SP_W-1:0]  best_v,
    output logic [PWR_W-1:0] best_p
);

    logic             tmr_clr;
    logic             tmr_expired;
    logic [TMR_W-1:0] tmr_limit;
    logic             pk_clr;
    logic             pk_sample;

    smc_seq #(.SP_W(SP_W), .PWR_W(PWR_W), .TMR_W(TMR_W)) u_seq (
        .clk         (clk),
        .rst         (rst),
        .run         (run),
        .cfg_vmin    (cfg_vmin),
        .cfg_voc     (cfg_voc),
        .cfg_step    (cfg_step),
        .cfg_settle  (cfg_settle),
        .cfg_hold    (cfg_hold),
        .pwr_valid   (pwr_valid),
        .tmr_expired (tmr_expired),
        .best_v      (best_v),
        .best_p      (best_p),
        .vset        (vset),
        .tmr_clr     (tmr_clr),
        .tmr_limit   (tmr_limit),
        .pk_clr      (pk_clr),
        .pk_sample   (pk_sample),
        .meas_req    (meas_req),
        .done        (done)
    );

    smc_interval #(.TMR_W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .limit   (tmr_limit),
        .expired (tmr_expired)
    );

    smc_peak #(.SP_W(SP_W), .PWR_W(PWR_W)) u_peak (
        .clk       (clk),
        .rst       (rst),
        .clr       (pk_clr),
        .init_v    (cfg_vmin),
        .sample_en (pk_sample),
        .pwr       (pwr_in),
        .v_now     (vset),
        .best_v    (best_v),
        .best_p    (best_p)
    );

endmodule

// File: tb/sweep_mpp_ctrl_test.sv
module sweep_mpp_ctrl_test;

    localparam int SP_W  = 10;
    localparam int PWR_W = 16;
    localparam int TMR_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             run = 1'b0;
    logic [SP_W-1:0]  cfg_vmin = '0;
    logic [SP_W-1:0]  cfg_voc = '0;
    logic [SP_W-1:0]  cfg_step = '0;
    logic [TMR_W-1:0] cfg_settle = '0;
    logic [TMR_W-1:0] cfg_hold = '0;
    logic [PWR_W-1:0] pwr_in = '0;
    logic             pwr_valid = 1'b0;
    logic [SP_W-1:0]  vset;
    logic             meas_req;
    logic             done;
    logic [SP_W-1:0]  best_v;
    logic [PWR_W-1:0] best_p;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    sweep_mpp_ctrl #(.SP_W(SP_W), .PWR_W(PWR_W), .TMR_W(TMR_W)) uut (
        .clk(clk), .rst(rst), .run(run),
        .cfg_vmin(cfg_vmin), .cfg_voc(cfg_voc), .cfg_step(cfg_step),
        .cfg_settle(cfg_settle), .cfg_hold(cfg_hold),
        .pwr_in(pwr_in), .pwr_valid(pwr_valid),
        .vset(vset), .meas_req(meas_req), .done(done),
        .best_v(best_v), .best_p(best_p)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // power curve seen by the bench: 0 parabola, 1 flat, 2 twin peaks
    function automatic int curve(input int kind, input int v, input int a, input int b);
        int d;
        case (kind)
            0: begin
                d = v - a;
                return (d * d > 50000) ? 0 : 50000 - d * d;
            end
            1: return 700;
            default: return (v == a || v == b) ? 5000 : 100;
        endcase
    endfunction

    task automatic finish_scan(input int hold);
        for (int k = 0; k < 5000; k++) begin
            @(negedge clk);
            pwr_valid = 1'b0;
            if (done) break;
            if (meas_req) begin
                pwr_valid = 1'b1;
                pwr_in    = '0;
            end
        end
        run = 1'b0;
        repeat (hold + 3) @(negedge clk);
    endtask

    task automatic scan_case(input string name, input int vmin, input int voc,
                             input int step, input int settle, input int hold,
                             input int kind, input int ca, input int cb,
                             input int delay, input bit junk, input bit rescan);
        int exp_v, bp, bv, last, k, waitn, eff, p;
        bit ended, got_done;
        eff = (step == 0) ? 1 : step;
        cfg_vmin = SP_W'(vmin); cfg_voc = SP_W'(voc); cfg_step = SP_W'(step);
        cfg_settle = TMR_W'(settle); cfg_hold = TMR_W'(hold);
        exp_v = vmin; bp = 0; bv = vmin; last = 0; waitn = 0;
        ended = 0; got_done = 0;
        run = 1'b1; pwr_valid = 1'b0;
        for (k = 1; k < 5000; k++) begin
            @(negedge clk);
            pwr_valid = 1'b0; pwr_in = '0;
            if (done) begin
                got_done = 1;
                break;
            end
            if (k == 1) chk(best_p == 0 && best_v == SP_W'(vmin), "R2", {name, " cleared record"}, int'(best_p), 0);
            if (meas_req) begin
                if (waitn == 0) begin
                    chk(k - last == settle + 2, "R3", {name, " settle gap"}, k - last, settle + 2);
                    chk(!ended, "R7", {name, " request after ceiling"}, 1, 0);
                end
                chk(int'(vset) == exp_v, "R6", {name, " setpoint"}, int'(vset), exp_v);
                if (waitn < delay) begin
                    waitn++;
                end else begin
                    p = curve(kind, exp_v, ca, cb);
                    pwr_valid = 1'b1; pwr_in = PWR_W'(p);
                    if (p > bp) begin bp = p; bv = exp_v; end
                    last = k; waitn = 0;
                    if (exp_v >= voc) ended = 1;
                    else exp_v = (exp_v + eff >= voc) ? voc : exp_v + eff;
                end
            end else if (junk) begin
                pwr_valid = 1'b1; pwr_in = '1;   // R4: stray strobe must be ignored
            end
        end
        chk(got_done, "R7", {name, " done seen"}, int'(got_done), 1);
        chk(ended, "R6", {name, " all setpoints visited"}, int'(ended), 1);
        chk(k - last == 1, "R7", {name, " done latency"}, k - last, 1);
        chk(int'(best_v) == bv, "R5", {name, " best setpoint"}, int'(best_v), bv);
        chk(int'(best_p) == bp, "R5", {name, " best power"}, int'(best_p), bp);
        @(negedge clk);
        chk(!done, "R7", {name, " done width"}, int'(done), 0);
        chk(int'(vset) == bv, "R7", {name, " park value"}, int'(vset), bv);
        run = rescan;
        for (int j = 2; j <= hold + 1; j++) begin
            @(negedge clk);
            chk(int'(vset) == bv && !meas_req, "R8", {name, " hold"}, int'(vset), bv);
        end
        @(negedge clk);
        chk(!meas_req, "R8", {name, " hold end request"}, int'(meas_req), 0);
        if (rescan) begin
            chk(int'(vset) == vmin && best_p == 0 && int'(best_v) == vmin, "R2",
                {name, " rescan start"}, int'(vset), vmin);
            for (int j = 0; j < settle; j++) begin
                @(negedge clk);
                chk(!meas_req, "R3", {name, " rescan settle"}, int'(meas_req), 0);
            end
            @(negedge clk);
            chk(meas_req, "R3", {name, " rescan request"}, int'(meas_req), 1);
            finish_scan(hold);
        end else begin
            chk(int'(vset) == bv, "R8", {name, " idle keeps setpoint"}, int'(vset), bv);
            repeat (settle + 4) begin
                @(negedge clk);
                chk(!meas_req, "R8", {name, " idle"}, int'(meas_req), 0);
            end
        end
    endtask

    task automatic reset_case();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(vset == 0 && best_v == 0, "R1", "reset setpoints", int'(vset), 0);
        chk(best_p == 0, "R1", "reset power", int'(best_p), 0);
        chk(!meas_req && !done, "R1", "reset strobes", int'(meas_req) + int'(done), 0);
        rst = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        reset_case();
        // clamped last step 380 -> 400, parabola, then rescan
        scan_case("parabola", 100, 400, 35, 3, 5, 0, 247, 0, 0, 0, 1);
        // twin equal peaks: lower one must win (R5)
        scan_case("twin", 20, 200, 20, 1, 2, 2, 60, 120, 0, 0, 0);
        // flat curve, step of zero acts as one
        scan_case("flat", 10, 14, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        // floor above ceiling: single measurement (R9)
        scan_case("degenerate", 500, 300, 10, 2, 1, 0, 500, 0, 0, 0, 0);
        // late replies and stray strobes (R3, R4)
        scan_case("late_junk", 0, 90, 30, 0, 0, 0, 61, 0, 3, 1, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule